// File: doc/BRIEF.md
# Performance Monitor Counter Unit

A per-core block that counts hardware events for profiling. It holds one free-running 32-bit cycle counter and a parameterised number of 32-bit event counters, four by default. Each event counter is bound to one of 256 single-cycle pulse lines through its own 8-bit event code. Code zero is a software increment that the event lines cannot trigger. When any counter wraps, the unit records an overflow flag for that counter. A single level interrupt is raised whenever a flagged counter also has its interrupt enabled.

Software reaches the unit through a flat register port. A write is one cycle with `reg_we_i` high. Reads are combinational on `reg_addr_i`. The word addresses are: 0 control, 1 counter-enable set, 2 counter-enable clear, 3 interrupt-enable set, 4 interrupt-enable clear, 5 overflow flags, 6 software increment, 7 counter select, 8 event type, 9 event count, 10 cycle count. In every mask register, bit n belongs to event counter n and bit 31 belongs to the cycle counter. The event type and event count of a counter are reached through the select register.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, all counters, event types, enables, flags and the select register are zero, and `irq_o` and `export_en_o` are low.
- R2: Control (address 0) stores bit 0 global enable, bit 3 divide-by-64, bit 4 export enable and bit 5 debug stop. Bits 2:1 always read 0. Bits 15:11 read the number of event counters. `export_en_o` follows bit 4.
- R3: Writing 1s to address 1 or 3 sets the matching counter-enable or interrupt-enable bits. Writing 1s to address 2 or 4 clears them. Zero bits have no effect. Bits with no counter behind them read 0. Addresses 1 and 2 both read the counter-enable mask, and addresses 3 and 4 both read the interrupt-enable mask.
- R4: An event counter whose type is a nonzero code c adds one on each clock edge at which `event_i[c]` is high. Pulses on other lines do not change it.
- R5: A counter changes only when the global enable and its own enable bit are both set.
- R6: A counter of type 0 adds one for each write to address 6 that has a 1 in its bit position. `event_i[0]` is ignored.
- R7: A counter that wraps from 0xFFFFFFFF to 0 sets its flag at address 5. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R8: `irq_o` is high exactly while some flag bit and the matching interrupt-enable bit are both set.
- R9: Once enabled, the cycle counter adds one per clock. Counters accept any start value written to addresses 9 and 10.
- R10: Writing control bit 1 zeroes all event counters, and writing bit 2 zeroes the cycle counter. Each takes effect at that write's edge and leaves the other counters untouched.
- R11: With divide-by-64 set, the cycle counter adds one per 64 running cycles. The prescaler is cleared by the cycle-counter reset strobe.
- R12: With debug stop set, the cycle counter holds while `dbg_prohibit_i` is high.
- R13: The select register (address 7, 5 bits) picks the counter reached by addresses 8 and 9. A select value at or above the counter count reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| event_i | input | 256 | Event pulse lines indexed by event code |
| dbg_prohibit_i | input | 1 | Debug prohibit; stops the cycle counter when enabled |
| export_en_o | output | 1 | Export enable from control bit 4 |
| irq_o | output | 1 | Shared overflow interrupt |

## Verification
The bench drives counters across the all-ones wrap for both kinds of counter. A design that dropped the carry into the flag, or let the flag fall without a write-one, would leave the interrupt wrong. It checks that a zero-code counter ignores pulse line 0, and that a select value of 7 does not alias onto counter 3 through index truncation. The prescaler case takes 63 running cycles after a cycle reset, which must give no tick; a design that fails to clear the divider ticks early. Debug stop is tried with the prohibit pin both high and low, and each reset strobe is checked to leave the other kind of counter untouched.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CNT_W      = 32;
  localparam int MASK_W     = 32;
  localparam int CYC_BIT    = 31;
  localparam int EVT_CODE_W = 8;
  localparam int EVT_NUM    = 1 << EVT_CODE_W;
  localparam int SEL_W      = 5;
  localparam int ADDR_W     = 4;
  localparam int PRESC_W    = 6;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 4'd0,
    RA_EN_SET = 4'd1,
    RA_EN_CLR = 4'd2,
    RA_IE_SET = 4'd3,
    RA_IE_CLR = 4'd4,
    RA_FLAGS  = 4'd5,
    RA_SWINC  = 4'd6,
    RA_SEL    = 4'd7,
    RA_TYPE   = 4'd8,
    RA_EVCNT  = 4'd9,
    RA_CYCCNT = 4'd10
  } reg_addr_e;

  typedef struct packed {
    logic dbg_stop;
    logic export_en;
    logic div64;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter
  import pmu_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  count_en_i,
  input  logic [EVT_NUM-1:0]    evt_i,
  input  logic                  sw_inc_i,
  input  logic                  type_we_i,
  input  logic [EVT_CODE_W-1:0] type_wdata_i,
  input  logic                  cnt_we_i,
  input  logic [CNT_W-1:0]      cnt_wdata_i,
  input  logic                  clr_i,
  output logic [EVT_CODE_W-1:0] type_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  wrap_o
);
  logic [EVT_CODE_W-1:0] type_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  hit;
  logic                  inc;

  // code zero is reserved for software increments
  assign hit = (type_q == '0) ? sw_inc_i : evt_i[type_q];
  assign inc = count_en_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (type_we_i) type_q <= type_wdata_i;
      if (cnt_we_i)  cnt_q <= cnt_wdata_i;
      else if (clr_i) cnt_q <= '0;
      else if (inc)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign type_o = type_q;
  assign cnt_o  = cnt_q;
  assign wrap_o = inc & (&cnt_q) & ~cnt_we_i & ~clr_i;

  a_r7_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_o == '0))
    else $error("event counter wrap did not land on zero");

  a_r5_hold_when_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_en_i && !cnt_we_i && !clr_i) |=> $stable(cnt_o))
    else $error("gated event counter moved");
endmodule

// File: rtl/pmu_cyc_counter.sv
module pmu_cyc_counter
  import pmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             div64_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               tick;

  assign tick = run_i & (~div64_i | (&presc_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (clr_i)                 presc_q <= '0;
      else if (run_i && div64_i) presc_q <= presc_q + 1'b1;

      if (cnt_we_i)   cnt_q <= cnt_wdata_i;
      else if (clr_i) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick & (&cnt_q) & ~cnt_we_i & ~clr_i;

  a_r12_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we_i && !clr_i) |=> $stable(cnt_o))
    else $error("stopped cycle counter moved");

  a_r11_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_we_i && !clr_i && !(&cnt_o)) |=>
      (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1))
    else $error("cycle counter jumped by more than one");
endmodule

// File: rtl/pmu_flag_ctrl.sv
module pmu_flag_ctrl
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic              flag_clr_i,
  input  logic [MASK_W-1:0] wdata_i,
  input  logic [MASK_W-1:0] wrap_i,
  output logic [MASK_W-1:0] cnt_en_o,
  output logic [MASK_W-1:0] irq_en_o,
  output logic [MASK_W-1:0] flags_o,
  output logic              irq_o
);
  function automatic logic [MASK_W-1:0] impl_mask();
    logic [MASK_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CNT; i++) m[i] = 1'b1;
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [MASK_W-1:0] IMPL = impl_mask();

  for (genvar b = 0; b < MASK_W; b++) begin : g_bit
    if (IMPL[b]) begin : g_impl
      logic en_q, ie_q, flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          en_q   <= 1'b0;
          ie_q   <= 1'b0;
          flag_q <= 1'b0;
        end else begin
          if (en_set_i && wdata_i[b])      en_q <= 1'b1;
          else if (en_clr_i && wdata_i[b]) en_q <= 1'b0;
          if (ie_set_i && wdata_i[b])      ie_q <= 1'b1;
          else if (ie_clr_i && wdata_i[b]) ie_q <= 1'b0;
          // a fresh wrap beats a concurrent clear
          if (wrap_i[b])                     flag_q <= 1'b1;
          else if (flag_clr_i && wdata_i[b]) flag_q <= 1'b0;
        end
      end
      assign cnt_en_o[b] = en_q;
      assign irq_en_o[b] = ie_q;
      assign flags_o[b]  = flag_q;

      a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_o[b] && !(flag_clr_i && wdata_i[b])) |=> flags_o[b])
        else $error("overflow flag dropped without a clear");

      a_r8_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i[b] && irq_en_o[b] && !(ie_clr_i && wdata_i[b])) |=> irq_o)
        else $error("enabled overflow did not raise the interrupt");
    end else begin : g_tie
      logic unused_b;
      assign unused_b    = wdata_i[b] ^ wrap_i[b];
      assign cnt_en_o[b] = 1'b0;
      assign irq_en_o[b] = 1'b0;
      assign flags_o[b]  = 1'b0;
    end
  end

  assign irq_o = |(flags_o & irq_en_o);
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  input  logic [EVT_NUM-1:0] event_i,
  input  logic              dbg_prohibit_i,
  output logic              export_en_o,
  output logic              irq_o
);
  ctrl_t               ctrl_q;
  logic [SEL_W-1:0]    sel_q;
  logic                sel_valid;
  logic                wr_ctrl, wr_sel, wr_type, wr_evcnt, wr_cyccnt, wr_swinc;
  logic                evt_clr, cyc_clr;
  logic [MASK_W-1:0]   cnt_en, irq_en, flags, wrap_vec;
  logic [NUM_CNT-1:0]  evt_wrap;
  logic [CNT_W-1:0]    cnt_arr  [NUM_CNT];
  logic [EVT_CODE_W-1:0] type_arr [NUM_CNT];
  logic [CNT_W-1:0]    cyc_cnt;
  logic                cyc_wrap, cyc_run;
  logic [CNT_W-1:0]    sel_cnt;
  logic [EVT_CODE_W-1:0] sel_type;

  assign wr_ctrl   = reg_we_i && (reg_addr_i == RA_CTRL);
  assign wr_sel    = reg_we_i && (reg_addr_i == RA_SEL);
  assign wr_type   = reg_we_i && (reg_addr_i == RA_TYPE);
  assign wr_evcnt  = reg_we_i && (reg_addr_i == RA_EVCNT);
  assign wr_cyccnt = reg_we_i && (reg_addr_i == RA_CYCCNT);
  assign wr_swinc  = reg_we_i && (reg_addr_i == RA_SWINC);

  // reset bits are strobes, never stored
  assign evt_clr = wr_ctrl & reg_wdata_i[1];
  assign cyc_clr = wr_ctrl & reg_wdata_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.enable    <= reg_wdata_i[0];
        ctrl_q.div64     <= reg_wdata_i[3];
        ctrl_q.export_en <= reg_wdata_i[4];
        ctrl_q.dbg_stop  <= reg_wdata_i[5];
      end
      if (wr_sel) sel_q <= reg_wdata_i[SEL_W-1:0];
    end
  end

  assign sel_valid = sel_q < SEL_W'(NUM_CNT);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic hit_sel;
    assign hit_sel = sel_valid && (sel_q == SEL_W'(g));
    pmu_evt_counter u_cnt (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .count_en_i   (ctrl_q.enable & cnt_en[g]),
      .evt_i        (event_i),
      .sw_inc_i     (wr_swinc & reg_wdata_i[g]),
      .type_we_i    (wr_type & hit_sel),
      .type_wdata_i (reg_wdata_i[EVT_CODE_W-1:0]),
      .cnt_we_i     (wr_evcnt & hit_sel),
      .cnt_wdata_i  (reg_wdata_i),
      .clr_i        (evt_clr),
      .type_o       (type_arr[g]),
      .cnt_o        (cnt_arr[g]),
      .wrap_o       (evt_wrap[g])
    );
  end

  assign cyc_run = ctrl_q.enable & cnt_en[CYC_BIT] & ~(ctrl_q.dbg_stop & dbg_prohibit_i);

  pmu_cyc_counter u_cyc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (cyc_run),
    .div64_i     (ctrl_q.div64),
    .cnt_we_i    (wr_cyccnt),
    .cnt_wdata_i (reg_wdata_i),
    .clr_i       (cyc_clr),
    .cnt_o       (cyc_cnt),
    .wrap_o      (cyc_wrap)
  );

  always_comb begin
    wrap_vec = '0;
    for (int i = 0; i < NUM_CNT; i++) wrap_vec[i] = evt_wrap[i];
    wrap_vec[CYC_BIT] = cyc_wrap;
  end

  pmu_flag_ctrl #(.NUM_CNT(NUM_CNT)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_set_i   (reg_we_i && (reg_addr_i == RA_EN_SET)),
    .en_clr_i   (reg_we_i && (reg_addr_i == RA_EN_CLR)),
    .ie_set_i   (reg_we_i && (reg_addr_i == RA_IE_SET)),
    .ie_clr_i   (reg_we_i && (reg_addr_i == RA_IE_CLR)),
    .flag_clr_i (reg_we_i && (reg_addr_i == RA_FLAGS)),
    .wdata_i    (reg_wdata_i),
    .wrap_i     (wrap_vec),
    .cnt_en_o   (cnt_en),
    .irq_en_o   (irq_en),
    .flags_o    (flags),
    .irq_o      (irq_o)
  );

  always_comb begin
    sel_cnt  = '0;
    sel_type = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (sel_q == SEL_W'(i)) begin
        sel_cnt  = cnt_arr[i];
        sel_type = type_arr[i];
      end
    end
    case (reg_addr_i)
      RA_CTRL:   reg_rdata_o = {16'b0, SEL_W'(NUM_CNT), 5'b0, ctrl_q.dbg_stop,
                                ctrl_q.export_en, ctrl_q.div64, 2'b00, ctrl_q.enable};
      RA_EN_SET, RA_EN_CLR: reg_rdata_o = cnt_en;
      RA_IE_SET, RA_IE_CLR: reg_rdata_o = irq_en;
      RA_FLAGS:  reg_rdata_o = flags;
      RA_SEL:    reg_rdata_o = {{(CNT_W-SEL_W){1'b0}}, sel_q};
      RA_TYPE:   reg_rdata_o = {{(CNT_W-EVT_CODE_W){1'b0}}, sel_type};
      RA_EVCNT:  reg_rdata_o = sel_cnt;
      RA_CYCCNT: reg_rdata_o = cyc_cnt;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign export_en_o = ctrl_q.export_en;

  a_r10_cyc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_clr |=> (cyc_cnt == '0))
    else $error("cycle counter not cleared by reset strobe");

  a_r10_evt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_clr |=> (cnt_arr[0] == '0))
    else $error("event counter not cleared by reset strobe");
endmodule

// File: tb/tb_perf_mon_unit.sv
module tb_perf_mon_unit;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         reg_we = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [255:0] event_v = '0;
  logic         dbg = 1'b0;
  logic         export_en;
  logic         irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_mon_unit dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .reg_we_i       (reg_we),
    .reg_addr_i     (reg_addr),
    .reg_wdata_i    (reg_wdata),
    .reg_rdata_o    (reg_rdata),
    .event_i        (event_v),
    .dbg_prohibit_i (dbg),
    .export_en_o    (export_en),
    .irq_o          (irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk);
    #1 check(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic pulse(input int code);
    @(negedge clk);
    event_v[code] = 1'b1;
    @(posedge clk);
    #1 event_v[code] = 1'b0;
  endtask

  task automatic run_cycles(input logic [31:0] ctrl_val, input int waits);
    wr(4'd0, ctrl_val);
    repeat (waits) @(posedge clk);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 4'd0, 32'h0000_2000);
    rd_chk("R1 enables", 4'd1, 32'h0);
    rd_chk("R1 irq enables", 4'd3, 32'h0);
    rd_chk("R1 flags", 4'd5, 32'h0);
    rd_chk("R1 select", 4'd7, 32'h0);
    rd_chk("R1 event count", 4'd9, 32'h0);
    rd_chk("R1 cycle count", 4'd10, 32'h0);
    irq_chk("R1 irq", 1'b0);
    check("R1 export", {31'b0, export_en}, 32'h0);
  endtask

  task automatic t_ctrl();
    wr(4'd0, 32'h3F);
    rd_chk("R2 ctrl readback", 4'd0, 32'h0000_2039);
    check("R2 export pin", {31'b0, export_en}, 32'h1);
    wr(4'd0, 32'h0);
    check("R2 export off", {31'b0, export_en}, 32'h0);
  endtask

  task automatic t_masks();
    wr(4'd1, 32'h8000_0005);
    rd_chk("R3 enable set", 4'd1, 32'h8000_0005);
    wr(4'd2, 32'h1);
    rd_chk("R3 enable clear", 4'd2, 32'h8000_0004);
    wr(4'd1, 32'h0000_0F00);
    rd_chk("R3 unimplemented bits", 4'd1, 32'h8000_0004);
    wr(4'd2, 32'h0);
    rd_chk("R3 zero clear", 4'd1, 32'h8000_0004);
    wr(4'd3, 32'h8000_0002);
    wr(4'd4, 32'h8000_0000);
    rd_chk("R3 irq enable set/clear", 4'd4, 32'h0000_0002);
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd2, 32'hFFFF_FFFF);
    rd_chk("R3 all cleared", 4'd1, 32'h0);
  endtask

  task automatic t_events();
    wr(4'd1, 32'h2);
    wr(4'd7, 32'd1);
    wr(4'd8, 32'h05);
    rd_chk("R4 type readback", 4'd8, 32'h05);
    wr(4'd0, 32'h1);
    pulse(5); pulse(5); pulse(5);
    pulse(6); pulse(6);
    rd_chk("R4 event count", 4'd9, 32'd3);
    wr(4'd0, 32'h0);
    pulse(5);
    rd_chk("R5 global gate", 4'd9, 32'd3);
    wr(4'd0, 32'h1);
    wr(4'd2, 32'h2);
    pulse(5);
    rd_chk("R5 local gate", 4'd9, 32'd3);
    wr(4'd1, 32'h2);
    pulse(5);
    rd_chk("R5 both enabled", 4'd9, 32'd4);
  endtask

  task automatic t_swinc();
    wr(4'd7, 32'd2);
    wr(4'd8, 32'h00);
    wr(4'd1, 32'h4);
    pulse(0);
    rd_chk("R6 line zero ignored", 4'd9, 32'd0);
    wr(4'd6, 32'h4);
    wr(4'd6, 32'h4);
    rd_chk("R6 software increment", 4'd9, 32'd2);
    wr(4'd6, 32'h2);
    wr(4'd7, 32'd1);
    rd_chk("R6 non-zero type ignores swinc", 4'd9, 32'd4);
  endtask

  task automatic t_overflow();
    wr(4'd7, 32'd1);
    wr(4'd9, 32'hFFFF_FFFE);
    pulse(5);
    rd_chk("R9 start value", 4'd9, 32'hFFFF_FFFF);
    pulse(5);
    rd_chk("R7 wrap to zero", 4'd9, 32'h0);
    rd_chk("R7 flag set", 4'd5, 32'h2);
    irq_chk("R8 irq masked", 1'b0);
    wr(4'd3, 32'h2);
    irq_chk("R8 irq raised", 1'b1);
    wr(4'd5, 32'h1);
    rd_chk("R7 other flag bit", 4'd5, 32'h2);
    wr(4'd5, 32'h2);
    rd_chk("R7 flag cleared", 4'd5, 32'h0);
    irq_chk("R8 irq dropped", 1'b0);
  endtask

  task automatic t_cycles();
    wr(4'd0, 32'h0);
    wr(4'd10, 32'h0);
    wr(4'd1, 32'h8000_0000);
    run_cycles(32'h1, 9);
    rd_chk("R9 cycle count", 4'd10, 32'd10);
  endtask

  task automatic t_resets();
    wr(4'd7, 32'd2);
    wr(4'd0, 32'h2);
    rd_chk("R10 event counters cleared", 4'd9, 32'd0);
    rd_chk("R10 cycle untouched", 4'd10, 32'd10);
    wr(4'd0, 32'h4);
    rd_chk("R10 cycle cleared", 4'd10, 32'd0);
  endtask

  task automatic t_prescale();
    run_cycles(32'h9, 129);
    rd_chk("R11 divide by 64", 4'd10, 32'd2);
    wr(4'd0, 32'h4);
    run_cycles(32'h9, 62);
    rd_chk("R11 prescaler cleared", 4'd10, 32'd0);
    run_cycles(32'h9, 0);
    rd_chk("R11 prescaler boundary", 4'd10, 32'd1);
  endtask

  task automatic t_debug();
    wr(4'd10, 32'h0);
    dbg = 1'b1;
    run_cycles(32'h21, 9);
    rd_chk("R12 held under prohibit", 4'd10, 32'd0);
    run_cycles(32'h01, 4);
    rd_chk("R12 stop disabled", 4'd10, 32'd5);
    dbg = 1'b0;
    run_cycles(32'h21, 2);
    rd_chk("R12 prohibit low", 4'd10, 32'd8);
  endtask

  task automatic t_cyc_wrap();
    wr(4'd10, 32'hFFFF_FFFF);
    run_cycles(32'h1, 0);
    rd_chk("R7 cycle wrap", 4'd10, 32'h0);
    rd_chk("R7 cycle flag", 4'd5, 32'h8000_0000);
    irq_chk("R8 cycle flag masked", 1'b0);
    wr(4'd3, 32'h8000_0000);
    irq_chk("R8 cycle irq", 1'b1);
    wr(4'd4, 32'h8000_0000);
    irq_chk("R8 irq enable cleared", 1'b0);
    wr(4'd5, 32'h8000_0000);
  endtask

  task automatic t_select();
    wr(4'd7, 32'd3);
    wr(4'd9, 32'h0000_ABCD);
    wr(4'd7, 32'd7);
    rd_chk("R13 select readback", 4'd7, 32'd7);
    wr(4'd9, 32'h0000_1234);
    wr(4'd8, 32'h33);
    rd_chk("R13 out of range count", 4'd9, 32'h0);
    rd_chk("R13 out of range type", 4'd8, 32'h0);
    wr(4'd7, 32'd3);
    rd_chk("R13 no alias count", 4'd9, 32'h0000_ABCD);
    rd_chk("R13 no alias type", 4'd8, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_ctrl();
    t_masks();
    t_events();
    t_swinc();
    t_overflow();
    t_cycles();
    t_resets();
    t_prescale();
    t_debug();
    t_cyc_wrap();
    t_select();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule